// File: doc/BRIEF.md
# Command Response Capture FIFO

This block sits behind the sampler of a memory-card command line. After the host side has sent a command, it pulses `start_i` together with the response format it expects and a wait limit. The block then watches the sampled command-line bits, one per card-clock strobe, and waits for a start bit (a zero). It shifts the response into 16-bit words, filling each word from its top bit down, and pushes the words into an eight-entry FIFO that the host drains through a read strobe.

Short responses keep their leading byte (start bit, transmission bit and six-bit command index) in the upper byte of the first word. The checksum and the closing bit are never stored. Long responses drop their eight-bit header and keep the 128 bits that follow. The block checks a CRC-7 on short responses when asked to. It reports a missing response as a timeout. It ends every response with either a success pulse or an error pulse.

Top module: `rsp_capture`

## Requirements
- R1: The FIFO holds up to 8 words of 16 bits. `rd_data_o` shows the oldest word without a read (show-ahead), `rd_empty_o` is 1 when no word is held, and a cycle with `rd_i` high removes the shown word.
- R2: Stored response bits fill each word from bit 15 down to bit 0, in arrival order.
- R3: For both short formats (48-bit frame), frame bits 0..39 are stored: start, transmission, index and 32 argument bits. That gives three words, and the third word holds 8 bits in [15:8] with [7:0] zero. Frame bits 40..47 (checksum and end bit) are not stored.
- R4: For the long format (136-bit frame), frame bits 0..7 are discarded and bits 8..135 are stored as 8 words, the earliest-received bits first.
- R5: `fmt_i` codes: 0 = no response, 1 = short with CRC check, 2 = long, 3 = short without CRC check. With code 0, `end_pulse_o` is high in the cycle right after the `start_i` cycle and nothing is stored.
- R6: While the block waits for a start bit, each strobe carrying a 1 is counted. The strobe that brings the count to max(limit,1), where the limit is the 7-bit `tmo_limit_i` latched at start, sets `tmo_o` and pulses `err_pulse_o` in the next cycle; the block then stops listening. A start bit arriving on an earlier strobe begins reception.
- R7: For code 1, a CRC-7 (x^7+x^3+1, register cleared to zero) over frame bits 0..39 is compared with frame bits 40..46 (MSB first). A mismatch sets `crc_err_o`. Code 3 never sets it.
- R8: The cycle after the strobe of the last frame bit, exactly one of `end_pulse_o` (success) or `err_pulse_o` (CRC mismatch) is high for one cycle. The two are never high together.
- R9: A read strobe on an empty FIFO returns `rd_data_o` = 0 and does not disturb the words that are written later.
- R10: `start_i` empties the FIFO, clears `tmo_o` and `crc_err_o`, and latches the format and the limit.
- R11: After reset the FIFO is empty, `rd_data_o` is 0, and all flags and pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Arm for a new response |
| fmt_i | input | 2 | Response format code, sampled with start_i |
| tmo_limit_i | input | 7 | Wait limit in idle strobes, sampled with start_i |
| cmd_bit_i | input | 1 | Sampled command-line bit |
| cmd_bit_vld_i | input | 1 | Strobe: cmd_bit_i is a new card-clock sample |
| rd_i | input | 1 | Host read strobe |
| rd_data_o | output | 16 | Oldest FIFO word, zero when empty |
| rd_empty_o | output | 1 | FIFO holds no word |
| tmo_o | output | 1 | Response timeout flag |
| crc_err_o | output | 1 | Response CRC error flag |
| end_pulse_o | output | 1 | One-cycle successful end of response |
| err_pulse_o | output | 1 | One-cycle response error |

## Verification
Pulses and flags are due one cycle after the clock edge that takes the deciding strobe or `start_i`. A FIFO word is visible on `rd_data_o` from the edge that takes its last bit, and a read strobe advances the output at the next edge. The bench drives every strobe and read on a falling edge and samples the outputs at the following falling edge, which is after exactly one rising edge. Pulse checks therefore sit directly after the strobe that should cause them. The scoreboard compares the queued words one by one as the FIFO is drained.

// File: rtl/rsp_capture_pkg.sv
package rsp_capture_pkg;

  typedef enum logic [1:0] {
    FMT_NONE      = 2'd0,
    FMT_SHORT_CRC = 2'd1,
    FMT_LONG      = 2'd2,
    FMT_SHORT_RAW = 2'd3
  } rsp_fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RECV = 2'd2
  } rsp_state_e;

  // One serial step of the x^7 + x^3 + 1 checksum.
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5], c[4], c[3], c[2] ^ fb, c[1], c[0], fb};
  endfunction

endpackage

// File: rtl/rsp_crc7.sv
module rsp_crc7 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       bit_i,
  output logic [6:0] crc
);
  import rsp_capture_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= crc7_step(crc, bit_i);
  end

endmodule

// File: rtl/rsp_packer.sv
module rsp_packer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         bit_i,
  input  logic         last,
  output logic         word_vld,
  output logic [W-1:0] word
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;
  logic [W-1:0]  nsh;
  logic          full_w;

  assign nsh      = {sh[W-2:0], bit_i};
  assign full_w   = (cnt == CW'(W-1));
  assign word_vld = en & (full_w | last);
  assign word     = full_w ? nsh : (nsh << (CW'(W-1) - cnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (clr || word_vld) begin
      sh  <= '0;
      cnt <= '0;
    end else if (en) begin
      sh  <= nsh;
      cnt <= cnt + 1'b1;
    end
  end

  AST_PAD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !full_w) |-> (word[0] == 1'b0)); // R3

endmodule

// File: rtl/rsp_fifo.sv
module rsp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R1
  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> (empty && $stable(rp))); // R9

endmodule

// File: rtl/rsp_capture.sv
module rsp_capture #(
  parameter int WORD_W     = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int TMO_W      = 7,
  parameter int SHORT_BITS = 48,
  parameter int LONG_BITS  = 136,
  parameter int HDR_BITS   = 8,
  parameter int CRC_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        fmt_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  input  logic              cmd_bit_i,
  input  logic              cmd_bit_vld_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_empty_o,
  output logic              tmo_o,
  output logic              crc_err_o,
  output logic              end_pulse_o,
  output logic              err_pulse_o
);
  import rsp_capture_pkg::*;

  localparam int IDX_W    = $clog2(LONG_BITS + 1);
  localparam int SHORT_HI = SHORT_BITS - CRC_W - 2;   // last stored bit, short
  localparam int CRC_LO   = SHORT_HI + 1;
  localparam int CRC_HI   = SHORT_BITS - 2;

  rsp_state_e        st;
  rsp_fmt_e          fmt_q;
  logic [TMO_W-1:0]  lim_q, wcnt;
  logic [IDX_W-1:0]  bidx, cur_idx, st_lo, st_hi, last_idx;
  logic [CRC_W-1:0]  rx_crc, calc_crc;
  logic              tmo_q, crcerr_q, end_q, err_q;

  // Named internal events
  logic in_wait, in_recv, is_long, take, idle_bit, tmo_hit;
  logic store_en, store_last, crc_en, rxcrc_en, frame_end, crc_bad;
  logic word_vld, fifo_full;
  logic [WORD_W-1:0] word;

  assign in_wait  = (st == ST_WAIT);
  assign in_recv  = (st == ST_RECV);
  assign is_long  = (fmt_q == FMT_LONG);
  assign take     = cmd_bit_vld_i & ~start_i & ((in_wait & ~cmd_bit_i) | in_recv);
  assign idle_bit = cmd_bit_vld_i & ~start_i & in_wait & cmd_bit_i;
  assign tmo_hit  = idle_bit &
                    (((TMO_W+1)'(wcnt) + 1'b1) >= (TMO_W+1)'(lim_q));
  assign cur_idx  = in_wait ? '0 : bidx;
  assign st_lo    = is_long ? IDX_W'(HDR_BITS)      : '0;
  assign st_hi    = is_long ? IDX_W'(LONG_BITS - 1) : IDX_W'(SHORT_HI);
  assign last_idx = is_long ? IDX_W'(LONG_BITS - 1) : IDX_W'(SHORT_BITS - 1);

  assign store_en   = take & (cur_idx >= st_lo) & (cur_idx <= st_hi);
  assign store_last = (cur_idx == st_hi);
  assign crc_en     = take & ~is_long & (cur_idx <= IDX_W'(SHORT_HI));
  assign rxcrc_en   = take & ~is_long & (cur_idx >= IDX_W'(CRC_LO)) &
                      (cur_idx <= IDX_W'(CRC_HI));
  assign frame_end  = take & (cur_idx == last_idx);
  assign crc_bad    = (fmt_q == FMT_SHORT_CRC) & (rx_crc != calc_crc);

  rsp_crc7 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(start_i), .en(crc_en),
    .bit_i(cmd_bit_i), .crc(calc_crc)
  );

  rsp_packer #(.W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(start_i), .en(store_en),
    .bit_i(cmd_bit_i), .last(store_last), .word_vld(word_vld), .word(word)
  );

  rsp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(start_i), .push(word_vld), .din(word),
    .pop(rd_i), .dout(rd_data_o), .empty(rd_empty_o), .full(fifo_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; fmt_q <= FMT_NONE; lim_q <= '0; wcnt <= '0;
      bidx <= '0; rx_crc <= '0; tmo_q <= 1'b0; crcerr_q <= 1'b0;
      end_q <= 1'b0; err_q <= 1'b0;
    end else begin
      end_q <= 1'b0;
      err_q <= 1'b0;
      if (start_i) begin
        fmt_q    <= rsp_fmt_e'(fmt_i);
        lim_q    <= tmo_limit_i;
        wcnt     <= '0;
        bidx     <= '0;
        rx_crc   <= '0;
        tmo_q    <= 1'b0;
        crcerr_q <= 1'b0;
        if (rsp_fmt_e'(fmt_i) == FMT_NONE) begin
          end_q <= 1'b1;
          st    <= ST_IDLE;
        end else begin
          st <= ST_WAIT;
        end
      end else begin
        if (idle_bit) begin
          if (tmo_hit) begin
            tmo_q <= 1'b1;
            err_q <= 1'b1;
            st    <= ST_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        if (take) begin
          bidx <= cur_idx + 1'b1;
          if (in_wait) st <= ST_RECV;
        end
        if (rxcrc_en) rx_crc <= {rx_crc[CRC_W-2:0], cmd_bit_i};
        if (frame_end) begin
          st <= ST_IDLE;
          if (crc_bad) begin
            crcerr_q <= 1'b1;
            err_q    <= 1'b1;
          end else begin
            end_q <= 1'b1;
          end
        end
      end
    end
  end

  assign tmo_o       = tmo_q;
  assign crc_err_o   = crcerr_q;
  assign end_pulse_o = end_q;
  assign err_pulse_o = err_q;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(end_pulse_o && err_pulse_o)); // R8
  AST_TMO_RAISES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_o) |-> err_pulse_o); // R6
  AST_CRC_RAISES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_err_o) |-> err_pulse_o); // R7
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse_o |=> !err_pulse_o); // R8
  AST_NO_STORE_OF_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    rxcrc_en |-> !store_en); // R3
  AST_OUTCOME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (end_pulse_o || err_pulse_o) |-> (st == ST_IDLE)); // R8

endmodule

// File: tb/rsp_capture_test.sv
module rsp_capture_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  fmt_i = '0;
  logic [6:0]  tmo_limit_i = '0;
  logic        cmd_bit_i = 1'b1;
  logic        cmd_bit_vld_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [15:0] rd_data_o;
  logic        rd_empty_o, tmo_o, crc_err_o, end_pulse_o, err_pulse_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [15:0] exp_q [$];

  rsp_capture uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fmt_i(fmt_i),
    .tmo_limit_i(tmo_limit_i), .cmd_bit_i(cmd_bit_i),
    .cmd_bit_vld_i(cmd_bit_vld_i), .rd_i(rd_i), .rd_data_o(rd_data_o),
    .rd_empty_o(rd_empty_o), .tmo_o(tmo_o), .crc_err_o(crc_err_o),
    .end_pulse_o(end_pulse_o), .err_pulse_o(err_pulse_o)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference checksum by long division of msg * x^7 by 1_0001_001.
  function automatic logic [6:0] crc_ref(input logic [39:0] m);
    logic [46:0] v;
    v = {m, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (v[i]) v[i -: 8] = v[i -: 8] ^ 8'b1000_1001;
    return v[6:0];
  endfunction

  task automatic arm(input logic [1:0] f, input logic [6:0] lim);
    fmt_i = f; tmo_limit_i = lim; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic strobe(input logic b);
    cmd_bit_i = b; cmd_bit_vld_i = 1'b1;
    @(negedge clk);
    cmd_bit_vld_i = 1'b0; cmd_bit_i = 1'b1;
  endtask

  // Driver: short frame, expected words go to the scoreboard.
  task automatic send_short(input logic [5:0] idx, input logic [31:0] arg, input bit spoil);
    logic [39:0] head;
    logic [6:0]  c;
    logic [47:0] fr;
    head = {2'b00, idx, arg};
    c = crc_ref(head) ^ (spoil ? 7'h05 : 7'h00);
    fr = {head, c, 1'b1};
    exp_q.push_back(fr[47:32]);
    exp_q.push_back(fr[31:16]);
    exp_q.push_back({fr[15:8], 8'h00});
    for (int i = 47; i >= 0; i--) strobe(fr[i]);
  endtask

  task automatic send_long(input logic [127:0] pl);
    logic [135:0] fr;
    fr = {2'b00, 6'b111111, pl};
    for (int k = 7; k >= 0; k--) exp_q.push_back(pl[k*16 +: 16]);
    for (int i = 135; i >= 0; i--) strobe(fr[i]);
  endtask

  task automatic rd_pulse();
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  // Monitor: pops the scoreboard as the design's words come out.
  task automatic drain(input string tag);
    logic [15:0] e;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      check({tag, " word"}, rd_data_o, e);
      rd_pulse();
    end
    check({tag, " empty after drain"}, rd_empty_o, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 empty", rd_empty_o, 1'b1);
    check("R11 data", rd_data_o, 16'h0);
    check("R11 flags", {tmo_o, crc_err_o, end_pulse_o, err_pulse_o}, 4'b0);

    // R9 read while empty
    rd_pulse();
    check("R9 empty read data", rd_data_o, 16'h0);
    check("R9 still empty", rd_empty_o, 1'b1);

    // R5 no-response format
    arm(2'd0, 7'd10);
    check("R5 end pulse for code 0", end_pulse_o, 1'b1);
    check("R5 nothing stored", rd_empty_o, 1'b1);
    @(negedge clk);
    check("R8 pulse is one cycle", end_pulse_o, 1'b0);

    // R3 R7 short with good checksum, R2 packing, R9 pointer untouched
    arm(2'd1, 7'h7f);
    strobe(1'b1); strobe(1'b1);
    send_short(6'h11, 32'hDEAD_BEEF, 1'b0);
    check("R8 R7 success end pulse", end_pulse_o, 1'b1);
    check("R8 no err pulse", err_pulse_o, 1'b0);
    check("R7 no crc flag", crc_err_o, 1'b0);
    check("R1 not empty", rd_empty_o, 1'b0);
    drain("R2 R3 R9 short crc");

    // R7 bad checksum on checked format
    arm(2'd1, 7'h7f);
    send_short(6'h2A, 32'h1234_5678, 1'b1);
    check("R7 err pulse on mismatch", err_pulse_o, 1'b1);
    check("R8 no end pulse on error", end_pulse_o, 1'b0);
    check("R7 crc flag set", crc_err_o, 1'b1);
    drain("R3 short bad crc");

    // R10 start clears flags and FIFO
    arm(2'd3, 7'h7f);
    check("R10 crc flag cleared", crc_err_o, 1'b0);
    send_short(6'h05, 32'h0000_0001, 1'b1);
    check("R7 code 3 ignores checksum", crc_err_o, 1'b0);
    check("R8 code 3 end pulse", end_pulse_o, 1'b1);
    exp_q.delete();
    arm(2'd0, 7'd1);
    check("R10 fifo flushed", rd_empty_o, 1'b1);

    // R4 long response fills all 8 entries
    arm(2'd2, 7'h7f);
    send_long(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
    check("R4 end pulse", end_pulse_o, 1'b1);
    check("R4 no crc flag", crc_err_o, 1'b0);
    drain("R1 R4 long");
    rd_pulse();
    check("R9 extra read data", rd_data_o, 16'h0);

    // R6 timeout
    arm(2'd1, 7'd5);
    for (int i = 0; i < 4; i++) begin
      strobe(1'b1);
      check("R6 no early timeout", {tmo_o, err_pulse_o}, 2'b00);
    end
    strobe(1'b1);
    check("R6 timeout flag", tmo_o, 1'b1);
    check("R6 err pulse", err_pulse_o, 1'b1);
    check("R6 no end pulse", end_pulse_o, 1'b0);
    strobe(1'b0);
    check("R6 stops listening", rd_empty_o, 1'b1);
    arm(2'd0, 7'd5);
    check("R10 timeout cleared", tmo_o, 1'b0);

    // R6 limit zero behaves as one
    arm(2'd3, 7'd0);
    strobe(1'b1);
    check("R6 limit zero", tmo_o, 1'b1);

    finish_run();
  end

endmodule